// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 32K words by 8 bits. The host hands it a single-word read or write with a request strobe while `host_ready` is high. The controller then runs a fixed strobe sequence on the memory's active-low chip enable, write enable and output enable lines. The sequence keeps the address and write data steady in registers for the whole cycle. When the access is complete, the controller pulses `host_done` for one clock.

Each phase is timed by a cycle count. The count is derived at elaboration from the memory's minimum nanosecond constraints and the clock period, always rounded up. A write is ended by write enable rising, with output enable held high for the whole write. A read holds chip enable and output enable low until every access time has elapsed, and captures the data on the edge that ends the read. The controller then waits out the memory's output-float time before it will accept work that could drive the shared data bus.

With the default 10 ns clock the counts are as follows:
- a read access lasts 7 cycles;
- the write-enable pulse lasts 5 cycles;
- the bus turnaround after a read lasts 3 cycles.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the memory strobes are idle: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0. In the same cycles `host_ready` is 1 and `host_done` is 0.
- R2: `host_ready` is 1 only while the controller is idle with all strobes inactive. A `host_req` that arrives while `host_ready` is 0 is ignored and has no effect on the memory.
- R3: A write (`host_wr`=1) proceeds in four steps while `mem_oe_n` stays 1 throughout:
  - on the clock after acceptance, chip enable goes low and the data bus is driven;
  - one cycle later write enable falls;
  - write enable rises one cycle before chip enable rises and the bus is released;
  - `host_done` pulses WP+2 cycles after the accepting edge, and the driven data is stored at the address.
- R4: The write-enable low pulse lasts exactly WP cycles, where WP is the largest of:
  - ceil(50/T);
  - ceil(60/T)-1;
  - ceil(30/T)-1;
  - ceil(70/T)-2.
  Here T is the clock period in ns.
- R5: A read (`host_wr`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with the bus not driven, for RD = max(ceil(70/T), ceil(35/T)) cycles. `mem_dq_in` is captured on the edge that ends this window and appears on `host_rdata` together with a `host_done` pulse RD cycles after the accepting edge.
- R6: After a read, `host_ready` stays 0 for TA = max(1, ceil(25/T)) cycles beyond the `host_done` pulse. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, nor within TA cycles after `mem_oe_n` rises.
- R7: `mem_addr` and `mem_dq_out` are registered at acceptance. They stay unchanged for as long as `mem_ce_n` is 0, whatever the host inputs do.
- R8: `host_done` is a single-cycle pulse, one per accepted request. `host_rdata` holds the last read value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, taken when host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle and able to accept |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value driven onto the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Value read from the memory data bus |

## Verification
A wrong phase count shows within one transaction, in three ways:
- the write-enable low run differs from WP;
- `host_done` arrives at the wrong cycle;
- on a read, the bench memory model still returns filler data at the capture edge, so `host_rdata` is wrong on that same completion.

A wrong state after a read shows as `mem_dq_oe` rising inside the float window, or as `host_ready` returning early. Both are visible within TA cycles of the read. A busy-time request that is wrongly accepted is caught at the next read of the address it targeted, which returns the wrong data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS,
    ST_RTURN
  } ctl_state_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  function automatic int ceil_cycles(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // read window: every access time must have elapsed
  function automatic int read_cycles(input int per, input int t_rc, input int t_aa,
                                     input int t_ace, input int t_doe);
    return imax(imax(ceil_cycles(t_rc, per), ceil_cycles(t_aa, per)),
                imax(imax(ceil_cycles(t_ace, per), ceil_cycles(t_doe, per)), 1));
  endfunction

  // write-enable pulse: one setup and one hold cycle surround it
  function automatic int wpulse_cycles(input int per, input int t_pwe, input int t_sce,
                                       input int t_aw, input int t_sd, input int t_wc);
    int w;
    w = imax(ceil_cycles(t_pwe, per), ceil_cycles(t_sce, per) - 1);
    w = imax(w, ceil_cycles(t_aw, per) - 1);
    w = imax(w, ceil_cycles(t_sd, per) - 1);
    w = imax(w, ceil_cycles(t_wc, per) - 2);
    return imax(w, 1);
  endfunction

  function automatic int turn_cycles(input int per, input int t_hz);
    return imax(ceil_cycles(t_hz, per), 1);
  endfunction

  // strobe levels owned by each state
  function automatic strobe_t strobes_for(input ctl_state_t s);
    strobe_t r;
    r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (s)
      ST_WSETUP, ST_WHOLD: begin r.ce_n = 1'b0; r.dq_oe = 1'b1; end
      ST_WPULSE:           begin r.ce_n = 1'b0; r.we_n = 1'b0; r.dq_oe = 1'b1; end
      ST_RACCESS:          begin r.ce_n = 1'b0; r.oe_n = 1'b0; end
      default:             ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CW    = 4,
  parameter int RD_LD = 6,
  parameter int WP_LD = 4,
  parameter int TA_LD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic          expired,
  output logic          ready,
  output logic          accept,
  output logic          capture,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic          done
);
  ctl_state_t st, nxt;
  strobe_t    nxt_strb;

  always_comb begin
    nxt      = st;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (wr) begin
            nxt = ST_WSETUP;
          end else begin
            nxt      = ST_RACCESS;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_LD);
          end
        end
      end
      ST_WSETUP: begin
        nxt      = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(WP_LD);
      end
      ST_WPULSE:  if (expired) nxt = ST_WHOLD;
      ST_WHOLD:   nxt = ST_IDLE;
      ST_RACCESS: begin
        if (expired) begin
          capture  = 1'b1;
          nxt      = ST_RTURN;
          tmr_load = 1'b1;
          tmr_val  = CW'(TA_LD);
        end
      end
      ST_RTURN:   if (expired) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  assign nxt_strb = strobes_for(nxt);
  assign ready    = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      st    <= nxt;
      ce_n  <= nxt_strb.ce_n;
      we_n  <= nxt_strb.we_n;
      oe_n  <= nxt_strb.oe_n;
      dq_oe <= nxt_strb.dq_oe;
      done  <= capture | (st == ST_WHOLD);
    end
  end
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 70,
  parameter int T_AA_NS       = 70,
  parameter int T_ACE_NS      = 70,
  parameter int T_DOE_NS      = 35,
  parameter int T_WC_NS       = 70,
  parameter int T_PWE_NS      = 50,
  parameter int T_SCE_NS      = 60,
  parameter int T_AW_NS       = 60,
  parameter int T_SD_NS       = 30,
  parameter int T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC = read_cycles(CLK_PERIOD_NS, T_RC_NS, T_AA_NS, T_ACE_NS, T_DOE_NS);
  localparam int WP_CYC = wpulse_cycles(CLK_PERIOD_NS, T_PWE_NS, T_SCE_NS, T_AW_NS,
                                        T_SD_NS, T_WC_NS);
  localparam int TA_CYC = turn_cycles(CLK_PERIOD_NS, T_HZ_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), TA_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  // internal events, named for the checker
  logic          accept_evt;
  logic          capture_evt;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  sram_ctl_fsm #(
    .CW(CW), .RD_LD(RD_CYC - 1), .WP_LD(WP_CYC - 1), .TA_LD(TA_CYC - 1)
  ) u_fsm (
    .clk(clk), .rst(rst), .req(host_req), .wr(host_wr), .expired(tmr_expired),
    .ready(host_ready), .accept(accept_evt), .capture(capture_evt),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe),
    .done(host_done)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_io_regs #(.AW(ADDR_W), .DW(DATA_W)) u_io (
    .clk(clk), .rst(rst), .accept(accept_evt), .capture(capture_evt),
    .addr_in(host_addr), .wdata_in(host_wdata), .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(host_rdata)
  );
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int WP = 5,
  parameter int TA = 3,
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic          host_done,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          accept_evt,
  input logic          capture_evt
);
  logic [15:0] we_low_cnt;
  logic [15:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_cnt <= '0;
      quiet_cnt  <= 16'hFFFF;
    end else begin
      we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
      if (!mem_oe_n)                quiet_cnt <= '0;
      else if (quiet_cnt != 16'hFFFF) quiet_cnt <= quiet_cnt + 16'd1;
    end
  end

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R3
  we_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe));

  // R3
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> !mem_ce_n);

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WP)));

  // R5
  capture_window_chk: assert property (@(posedge clk) disable iff (rst)
    capture_evt |-> (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe));

  // R5
  capture_done_chk: assert property (@(posedge clk) disable iff (rst)
    capture_evt |=> host_done);

  // R6
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && quiet_cnt >= 16'(TA)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .WP(WP_CYC), .TA(TA_CYC), .AW(ADDR_W), .DW(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .host_done(host_done),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
  .accept_evt(accept_evt), .capture_evt(capture_evt)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
  localparam int TCK = 8;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int bmax(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  localparam int EXP_RD = bmax(cdiv(70, TCK), cdiv(35, TCK));
  localparam int EXP_WP = bmax(bmax(cdiv(50, TCK), cdiv(60, TCK) - 1),
                               bmax(cdiv(30, TCK) - 1, cdiv(70, TCK) - 2));
  localparam int EXP_TA = bmax(1, cdiv(25, TCK));

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_done;
  logic [7:0]  host_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #(TCK/2) clk = ~clk;

  sram_seq_ctrl #(.CLK_PERIOD_NS(TCK)) u0 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fill_val(input logic [14:0] a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model driven only by the controller's strobes
  logic [7:0] model  [int];
  logic [7:0] shadow [int];
  int  acc = 0, quiet = 1000, we_run = 0, last_we_run = 0;
  bit  prev_we_n = 1'b1, prev_ce_low = 1'b0, commit_drv = 1'b0;
  logic [14:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;
  int  viol_oe = 0, viol_bus = 0, viol_hold = 0;

  always @(negedge clk) begin
    if (rst) begin
      acc = 0; quiet = 1000; we_run = 0; prev_we_n = 1'b1; prev_ce_low = 1'b0;
    end else begin
      if (!prev_we_n && mem_we_n) begin
        last_we_run = we_run;
        commit_drv  = mem_dq_oe;
        if (!mem_ce_n) model[int'(mem_addr)] = mem_dq_out;
      end
      if (!mem_we_n) we_run++; else we_run = 0;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) acc++; else acc = 0;
      if (!mem_oe_n) quiet = 0; else if (quiet < 1000) quiet++;
      if (!mem_we_n && !mem_oe_n) viol_oe++;
      if (mem_dq_oe && (!mem_oe_n || quiet <= EXP_TA)) viol_bus++;
      if (!mem_ce_n && prev_ce_low && (mem_addr != prev_addr || mem_dq_out != prev_dq))
        viol_hold++;
      prev_ce_low = !mem_ce_n;
      prev_addr   = mem_addr;
      prev_dq     = mem_dq_out;
      prev_we_n   = mem_we_n;
      if (acc >= EXP_RD)
        mem_dq_in = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : fill_val(mem_addr);
      else
        mem_dq_in = 8'hEE;
    end
  end

  function automatic logic [7:0] expect_at(input logic [14:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : fill_val(a);
  endfunction

  logic [7:0] last_rd = 8'h00;

  // one transaction; poke issues a stray request while busy
  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d,
                       input bit poke, input logic [14:0] pa);
    int n, m;
    bit busy_ready;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_addr = 15'($urandom); host_wdata = 8'($urandom);
    n = 0; busy_ready = 1'b0;
    while (!host_done && n < 200) begin
      if (host_ready) busy_ready = 1'b1;
      if (poke && n == 2) begin
        host_req = 1'b1; host_wr = 1'b1; host_addr = pa; host_wdata = ~expect_at(pa);
      end else begin
        host_req = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    host_req = 1'b0;
    check(!busy_ready, "R2 ready low while busy", busy_ready, 0);
    if (w) begin
      shadow[int'(a)] = d;
      check(n == EXP_WP + 2, "R3 write done latency", n, EXP_WP + 2);
      check(last_we_run == EXP_WP, "R4 we pulse width", last_we_run, EXP_WP);
      check(commit_drv, "R3 data driven at we rise", commit_drv, 1);
      check(host_rdata == last_rd, "R8 rdata held over write", host_rdata, last_rd);
    end else begin
      check(n == EXP_RD, "R5 read done latency", n, EXP_RD);
      check(host_rdata == expect_at(a), "R5 read data", host_rdata, expect_at(a));
      last_rd = host_rdata;
    end
    m = 0;
    while (!host_ready && m < 200) begin @(negedge clk); m++; end
    if (!w) check(m == EXP_TA, "R6 turnaround length", m, EXP_TA);
    if (m == 0) @(negedge clk);
    check(!host_done, "R8 done single pulse", host_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  logic [14:0] pool [16];

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset",
          {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe, "R1 bus released in reset", mem_dq_oe, 0);
    check(host_ready && !host_done, "R1 ready/done in reset", {host_ready, host_done}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check(host_ready && mem_ce_n && !host_done, "R1 idle after reset",
          {host_ready, mem_ce_n, host_done}, 3'b110);

    // directed corners
    issue(1'b0, 15'h0123, 8'h00, 1'b0, 15'h0);
    issue(1'b1, 15'h0000, 8'hA5, 1'b0, 15'h0);
    issue(1'b1, 15'h7FFF, 8'h3C, 1'b1, 15'h0000);
    issue(1'b0, 15'h0000, 8'h00, 1'b0, 15'h0);
    issue(1'b0, 15'h7FFF, 8'h00, 1'b1, 15'h7FFF);
    issue(1'b1, 15'h7FFF, 8'hFF, 1'b0, 15'h0);
    issue(1'b0, 15'h7FFF, 8'h00, 1'b0, 15'h0);

    for (int i = 0; i < 16; i++) pool[i] = 15'($urandom);
    pool[0] = 15'h0000; pool[1] = 15'h7FFF;
    for (int i = 0; i < 200; i++) begin
      issue(1'($urandom), pool[$urandom % 16], 8'($urandom),
            ($urandom % 4) == 0, pool[$urandom % 16]);
    end
    for (int i = 0; i < 16; i++) issue(1'b0, pool[i], 8'h00, 1'b0, 15'h0);

    check(viol_oe == 0, "R3 oe high during write", viol_oe, 0);
    check(viol_bus == 0, "R6 no drive in float window", viol_bus, 0);
    check(viol_hold == 0, "R7 addr/data stable while selected", viol_hold, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule